// File: doc/BRIEF.md
# PIP Border and Background Colour Inserter

This block sits in the display pixel stream of a picture-in-picture controller and replaces selected pixels with constant colour samples. Upstream position logic marks each pixel with region flags: channel border, sub-picture border, main-picture border, picture interior, background, and an enlarged window used in factory mode. The block picks one region by a fixed priority. For a fill region it builds a Y/U/V sample from that region's settings byte. For the picture interior it passes the incoming picture sample through unchanged.

Each fill region has a settings byte with an enable bit, a 2-bit brightness code and a 3-bit colour code. A disabled region is drawn black. A disabled channel border borrows the sub-border settings. A polarity input negates U and V on border colours only. When factory mode is set together with the background enable, the enlarged window is flooded with the background colour. A global picture-in-picture enable gates only the fast-blanking output, so the colour path keeps running.

The pixel clock enable `pix_en` advances a two-stage pipeline. Y is unsigned; U and V are two's complement, all `PIX_W` bits wide.

Top module: `pipb_colour_inserter`

## Requirements
- R1: While `rst_n` is low, `y_o`, `u_o` and `v_o` are 0 and `fb_o` is 0.
- R2: Inputs sampled at one rising edge with `pix_en` high appear on the outputs after the second such edge. A rising edge with `pix_en` low changes no output and no pipeline state.
- R3: In each settings byte, bit 6 is the enable, bits 5:4 are the brightness code and bits 2:0 are the colour code. Bit 3 is ignored. Bit 7 is ignored except in `bg_cfg`.
- R4: Colour code bit 0 is blue, bit 1 is red and bit 2 is green, each at full scale F = 2^PIX_W-1 or 0. At full brightness the colour is Y=(77R+150G+29B)>>8, U=floor((B-Y)/2) and V=floor((R-Y)/2).
- R5: Brightness codes 0, 1, 2 and 3 multiply Y, U and V by 5/16, 8/16, 11/16 and 16/16 respectively, rounding toward minus infinity.
- R6: A selected background, main-border or sub-border region whose enable is 0 outputs Y=U=V=0, and `fb_o` still follows R12.
- R7: A selected channel border whose enable is 0 uses the whole sub-border settings byte (enable, brightness and colour).
- R8: The region priority is channel border, then sub border, then main border, then picture, then background.
- R9: The picture region outputs `pic_y`, `pic_u` and `pic_v` unchanged.
- R10: When `uv_inv` is 1, U and V of border colours (channel, sub, main) are negated after scaling. Background and picture samples are never negated.
- R11: When `bg_cfg` bits 7 and 6 are both 1, pixels with `fact_win` high output the background colour, whatever other flags are set. All other pixels output zeros with `fb_o` low. With bit 6 clear, bit 7 has no effect.
- R12: `fb_o` is 1 only when `pip_on` is 1 and some region is selected. With no region selected, Y=U=V=0. `pip_on` does not affect Y, U or V.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel-domain clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| pix_en | input | 1 | Pixel clock enable |
| pip_on | input | 1 | Global enable of fast blanking |
| uv_inv | input | 1 | Negate U/V on border colours |
| main_cfg | input | 8 | Main-border settings byte |
| sub_cfg | input | 8 | Sub-border settings byte |
| chan_cfg | input | 8 | Channel-border settings byte |
| bg_cfg | input | 8 | Background settings byte, bit 7 factory mode |
| hit_chan | input | 1 | Pixel lies on the selected channel border |
| hit_sub | input | 1 | Pixel lies on a sub-picture border |
| hit_main | input | 1 | Pixel lies on the main-picture border |
| hit_pic | input | 1 | Pixel lies inside a picture |
| hit_bg | input | 1 | Pixel lies in the background area |
| fact_win | input | 1 | Pixel lies in the enlarged factory window |
| pic_y | input | PIX_W | Picture luminance sample |
| pic_u | input | PIX_W | Picture U sample, two's complement |
| pic_v | input | PIX_W | Picture V sample, two's complement |
| y_o | output | PIX_W | Output luminance |
| u_o | output | PIX_W | Output U, two's complement |
| v_o | output | PIX_W | Output V, two's complement |
| fb_o | output | 1 | Fast-blanking flag |

## Verification
The bench builds the block with the default `PIX_W` of 8. This makes every one of the eight colours at all four brightness codes exactly predictable from the integer formulas, including the most negative U and V values (yellow and cyan) and the floor rounding of negative products. The directed scenarios step through the priority chain one flag at a time. They also cover channel-border fallback with the sub border both on and off, and factory mode with and without the background enable. A stall window checks that outputs hold while `pix_en` is low and that the two-edge latency holds.

// File: rtl/pipb_pkg.sv
package pipb_pkg;

  localparam int CFG_W   = 8;
  localparam int ON_BIT  = 6;
  localparam int LVL_HI  = 5;
  localparam int LVL_LO  = 4;
  localparam int COL_HI  = 2;
  localparam int FAC_BIT = 7;
  localparam int GAIN_W  = 5;

  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_PIC  = 2'd1,
    SRC_FILL = 2'd2
  } src_e;

  typedef struct packed {
    src_e       src;
    logic       on;
    logic [1:0] lvl;
    logic [2:0] code;
    logic       inv;
    logic       fb;
  } sel_t;

  // brightness code -> gain in sixteenths
  function automatic logic [GAIN_W-1:0] lvl_gain(input logic [1:0] lvl);
    case (lvl)
      2'd0:    lvl_gain = 5'd5;
      2'd1:    lvl_gain = 5'd8;
      2'd2:    lvl_gain = 5'd11;
      default: lvl_gain = 5'd16;
    endcase
  endfunction

  function automatic sel_t fill_from(input logic [CFG_W-1:0] cfg, input logic inv);
    sel_t s;
    s.src  = SRC_FILL;
    s.on   = cfg[ON_BIT];
    s.lvl  = cfg[LVL_HI:LVL_LO];
    s.code = cfg[COL_HI:0];
    s.inv  = inv;
    s.fb   = 1'b0;
    return s;
  endfunction

endpackage

// File: rtl/pipb_colour_lut.sv
module pipb_colour_lut #(
  parameter int PIX_W = 8
) (
  input  logic [2:0]       code_i,
  output logic [PIX_W-1:0] y_o,
  output logic [PIX_W-1:0] u_o,
  output logic [PIX_W-1:0] v_o
);

  localparam int N_COL = 8;
  localparam int FULL  = (1 << PIX_W) - 1;

  logic [PIX_W-1:0] y_tab [N_COL];
  logic [PIX_W-1:0] u_tab [N_COL];
  logic [PIX_W-1:0] v_tab [N_COL];

  for (genvar i = 0; i < N_COL; i++) begin : g_col
    localparam int BB = (i & 1) * FULL;
    localparam int RR = ((i >> 1) & 1) * FULL;
    localparam int GG = ((i >> 2) & 1) * FULL;
    localparam int YY = (77 * RR + 150 * GG + 29 * BB) >>> 8;
    localparam int UU = (BB - YY) >>> 1;
    localparam int VV = (RR - YY) >>> 1;
    assign y_tab[i] = PIX_W'(YY);
    assign u_tab[i] = PIX_W'(UU);
    assign v_tab[i] = PIX_W'(VV);
  end

  assign y_o = y_tab[code_i];
  assign u_o = u_tab[code_i];
  assign v_o = v_tab[code_i];

endmodule

// File: rtl/pipb_region_sel.sv
module pipb_region_sel
  import pipb_pkg::*;
#(
  parameter int PIX_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic             pip_on,
  input  logic             uv_inv,
  input  logic [CFG_W-1:0] main_cfg,
  input  logic [CFG_W-1:0] sub_cfg,
  input  logic [CFG_W-1:0] chan_cfg,
  input  logic [CFG_W-1:0] bg_cfg,
  input  logic             hit_chan,
  input  logic             hit_sub,
  input  logic             hit_main,
  input  logic             hit_pic,
  input  logic             hit_bg,
  input  logic             fact_win,
  input  logic [PIX_W-1:0] pic_y,
  input  logic [PIX_W-1:0] pic_u,
  input  logic [PIX_W-1:0] pic_v,
  output sel_t             sel_q,
  output logic [PIX_W-1:0] py_q,
  output logic [PIX_W-1:0] pu_q,
  output logic [PIX_W-1:0] pv_q
);

  sel_t sel_d;
  logic fac_mode;
  logic unused_cfg;

  assign unused_cfg = ^{main_cfg[FAC_BIT], main_cfg[3], sub_cfg[FAC_BIT], sub_cfg[3],
                        chan_cfg[FAC_BIT], chan_cfg[3], bg_cfg[3]};

  assign fac_mode = bg_cfg[FAC_BIT] & bg_cfg[ON_BIT];

  always_comb begin
    sel_d     = '0;
    sel_d.src = SRC_NONE;
    if (fac_mode) begin
      if (fact_win) sel_d = fill_from(bg_cfg, 1'b0);
    end else if (hit_chan) begin
      if (chan_cfg[ON_BIT]) sel_d = fill_from(chan_cfg, uv_inv);
      else                  sel_d = fill_from(sub_cfg, uv_inv);
    end else if (hit_sub) begin
      sel_d = fill_from(sub_cfg, uv_inv);
    end else if (hit_main) begin
      sel_d = fill_from(main_cfg, uv_inv);
    end else if (hit_pic) begin
      sel_d.src = SRC_PIC;
    end else if (hit_bg) begin
      sel_d = fill_from(bg_cfg, 1'b0);
    end
    sel_d.fb = pip_on & (sel_d.src != SRC_NONE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= '0;
      py_q  <= '0;
      pu_q  <= '0;
      pv_q  <= '0;
    end else if (en_i) begin
      sel_q <= sel_d;
      py_q  <= pic_y;
      pu_q  <= pic_u;
      pv_q  <= pic_v;
    end
  end

endmodule

// File: rtl/pipb_shade.sv
module pipb_shade
  import pipb_pkg::*;
#(
  parameter int PIX_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  sel_t             sel_i,
  input  logic [PIX_W-1:0] py_i,
  input  logic [PIX_W-1:0] pu_i,
  input  logic [PIX_W-1:0] pv_i,
  output logic [PIX_W-1:0] y_o,
  output logic [PIX_W-1:0] u_o,
  output logic [PIX_W-1:0] v_o,
  output logic             fb_o
);

  localparam int PY_W = PIX_W + GAIN_W;
  localparam int PC_W = PIX_W + GAIN_W + 1;

  logic [PIX_W-1:0]  base_y, base_u, base_v;
  logic [GAIN_W-1:0] gain;
  logic [PY_W-1:0]   y_prod;
  logic [PC_W-1:0]   u_prod, v_prod;
  logic [PIX_W-1:0]  y_sc, u_sc, v_sc, u_fin, v_fin;
  logic [PIX_W-1:0]  y_d, u_d, v_d;
  logic              unused_prod;

  pipb_colour_lut #(.PIX_W(PIX_W)) lut_i (
    .code_i (sel_i.code),
    .y_o    (base_y),
    .u_o    (base_u),
    .v_o    (base_v)
  );

  assign gain   = lvl_gain(sel_i.lvl);
  assign y_prod = {{GAIN_W{1'b0}}, base_y} * {{PIX_W{1'b0}}, gain};
  assign u_prod = {{(GAIN_W+1){base_u[PIX_W-1]}}, base_u} * {{(PIX_W+1){1'b0}}, gain};
  assign v_prod = {{(GAIN_W+1){base_v[PIX_W-1]}}, base_v} * {{(PIX_W+1){1'b0}}, gain};
  assign y_sc   = y_prod[PIX_W+3:4];
  assign u_sc   = u_prod[PIX_W+3:4];
  assign v_sc   = v_prod[PIX_W+3:4];
  assign u_fin  = sel_i.inv ? (~u_sc + PIX_W'(1)) : u_sc;
  assign v_fin  = sel_i.inv ? (~v_sc + PIX_W'(1)) : v_sc;

  assign unused_prod = ^{y_prod[3:0], y_prod[PY_W-1], u_prod[3:0], u_prod[PC_W-1:PIX_W+4],
                         v_prod[3:0], v_prod[PC_W-1:PIX_W+4]};

  always_comb begin
    y_d = '0;
    u_d = '0;
    v_d = '0;
    case (sel_i.src)
      SRC_PIC: begin
        y_d = py_i;
        u_d = pu_i;
        v_d = pv_i;
      end
      SRC_FILL: begin
        if (sel_i.on) begin
          y_d = y_sc;
          u_d = u_fin;
          v_d = v_fin;
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      y_o  <= '0;
      u_o  <= '0;
      v_o  <= '0;
      fb_o <= 1'b0;
    end else if (en_i) begin
      y_o  <= y_d;
      u_o  <= u_d;
      v_o  <= v_d;
      fb_o <= sel_i.fb;
    end
  end

endmodule

// File: rtl/pipb_colour_inserter.sv
module pipb_colour_inserter
  import pipb_pkg::*;
#(
  parameter int PIX_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pix_en,
  input  logic             pip_on,
  input  logic             uv_inv,
  input  logic [7:0]       main_cfg,
  input  logic [7:0]       sub_cfg,
  input  logic [7:0]       chan_cfg,
  input  logic [7:0]       bg_cfg,
  input  logic             hit_chan,
  input  logic             hit_sub,
  input  logic             hit_main,
  input  logic             hit_pic,
  input  logic             hit_bg,
  input  logic             fact_win,
  input  logic [PIX_W-1:0] pic_y,
  input  logic [PIX_W-1:0] pic_u,
  input  logic [PIX_W-1:0] pic_v,
  output logic [PIX_W-1:0] y_o,
  output logic [PIX_W-1:0] u_o,
  output logic [PIX_W-1:0] v_o,
  output logic             fb_o
);

  sel_t             sel_s1;
  logic [PIX_W-1:0] py_s1, pu_s1, pv_s1;

  pipb_region_sel #(.PIX_W(PIX_W)) sel_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .en_i     (pix_en),
    .pip_on   (pip_on),
    .uv_inv   (uv_inv),
    .main_cfg (main_cfg),
    .sub_cfg  (sub_cfg),
    .chan_cfg (chan_cfg),
    .bg_cfg   (bg_cfg),
    .hit_chan (hit_chan),
    .hit_sub  (hit_sub),
    .hit_main (hit_main),
    .hit_pic  (hit_pic),
    .hit_bg   (hit_bg),
    .fact_win (fact_win),
    .pic_y    (pic_y),
    .pic_u    (pic_u),
    .pic_v    (pic_v),
    .sel_q    (sel_s1),
    .py_q     (py_s1),
    .pu_q     (pu_s1),
    .pv_q     (pv_s1)
  );

  pipb_shade #(.PIX_W(PIX_W)) shade_i (
    .clk   (clk),
    .rst_n (rst_n),
    .en_i  (pix_en),
    .sel_i (sel_s1),
    .py_i  (py_s1),
    .pu_i  (pu_s1),
    .pv_i  (pv_s1),
    .y_o   (y_o),
    .u_o   (u_o),
    .v_o   (v_o),
    .fb_o  (fb_o)
  );

endmodule

// File: rtl/pipb_colour_inserter_chk.sv
module pipb_colour_inserter_chk #(
  parameter int PIX_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             pix_en,
  input logic             pip_on,
  input logic [PIX_W-1:0] y_o,
  input logic [PIX_W-1:0] u_o,
  input logic [PIX_W-1:0] v_o,
  input logic             fb_o
);

  // enabled edges since pip_on was last sampled high, saturating at 2
  logic [1:0] off_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) off_cnt <= 2'd0;
    else if (pix_en) begin
      if (pip_on)              off_cnt <= 2'd0;
      else if (off_cnt != 2'd2) off_cnt <= off_cnt + 2'd1;
    end
  end

  always @(posedge clk) begin
    if (!rst_n) begin
      AST_RESET_QUIET: assert (fb_o == 1'b0 && y_o == '0 && u_o == '0 && v_o == '0); // R1
    end
  end

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !pix_en |=> ($stable(y_o) && $stable(u_o) && $stable(v_o) && $stable(fb_o))); // R2

  AST_PIPOFF_NOBLANK: assert property (@(posedge clk) disable iff (!rst_n)
    (off_cnt == 2'd2) |-> !fb_o); // R12

  AST_FB_KNOWN: assert property (@(posedge clk) disable iff (!rst_n)
    !$isunknown({fb_o, y_o, u_o, v_o})); // R2

endmodule

bind pipb_colour_inserter pipb_colour_inserter_chk #(.PIX_W(PIX_W)) chk_i (
  .clk    (clk),
  .rst_n  (rst_n),
  .pix_en (pix_en),
  .pip_on (pip_on),
  .y_o    (y_o),
  .u_o    (u_o),
  .v_o    (v_o),
  .fb_o   (fb_o)
);

// File: tb/pipb_colour_inserter_tb.sv
module pipb_colour_inserter_tb_top;

  localparam int PIX_W = 8;

  logic clk = 1'b0;
  logic rst_n, pix_en, pip_on, uv_inv;
  logic [7:0] main_cfg, sub_cfg, chan_cfg, bg_cfg;
  logic hit_chan, hit_sub, hit_main, hit_pic, hit_bg, fact_win;
  logic [PIX_W-1:0] pic_y, pic_u, pic_v;
  logic [PIX_W-1:0] y_o, u_o, v_o;
  logic fb_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  pipb_colour_inserter #(.PIX_W(PIX_W)) dut_i (.*);

  // settings byte: bit6 enable, bits5:4 brightness, bits2:0 colour
  function automatic logic [7:0] mk(input logic on, input logic [1:0] lvl, input logic [2:0] c);
    return {1'b0, on, lvl, 1'b0, c};
  endfunction

  // expected fill sample from R4/R5/R6/R10
  function automatic logic [23:0] fillc(input logic [7:0] cfg, input logic inv);
    int r, g, b, y, u, v, k;
    if (!cfg[6]) return 24'h0;
    b = cfg[0] ? 255 : 0;
    r = cfg[1] ? 255 : 0;
    g = cfg[2] ? 255 : 0;
    y = (77 * r + 150 * g + 29 * b) >>> 8;
    u = (b - y) >>> 1;
    v = (r - y) >>> 1;
    case (cfg[5:4])
      2'd0: k = 5;
      2'd1: k = 8;
      2'd2: k = 11;
      default: k = 16;
    endcase
    y = (y * k) >>> 4;
    u = (u * k) >>> 4;
    v = (v * k) >>> 4;
    if (inv) begin
      u = -u;
      v = -v;
    end
    return {y[7:0], u[7:0], v[7:0]};
  endfunction

  task automatic chk(input string tag, input logic [23:0] eyuv, input logic efb);
    checks++;
    if ({y_o, u_o, v_o} !== eyuv || fb_o !== efb) begin
      errors++;
      $display("FAIL %s: got yuv=%h fb=%b expected yuv=%h fb=%b", tag, {y_o, u_o, v_o}, fb_o, eyuv, efb);
    end
  endtask

  task automatic run();
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic clear_hits();
    {hit_chan, hit_sub, hit_main, hit_pic, hit_bg, fact_win} = '0;
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 reset", 24'h0, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_colours();
    clear_hits();
    hit_bg = 1'b1;
    for (int c = 0; c < 8; c++) begin
      bg_cfg = mk(1'b1, 2'd3, 3'(c));
      run();
      chk($sformatf("R4 colour %0d", c), fillc(bg_cfg, 1'b0), 1'b1);
    end
  endtask

  task automatic t_levels();
    clear_hits();
    hit_bg = 1'b1;
    for (int l = 0; l < 4; l++) begin
      bg_cfg = mk(1'b1, 2'(l), 3'd6);
      run();
      chk($sformatf("R5 yellow level %0d", l), fillc(bg_cfg, 1'b0), 1'b1);
      bg_cfg = mk(1'b1, 2'(l), 3'd1);
      run();
      chk($sformatf("R5 blue level %0d", l), fillc(bg_cfg, 1'b0), 1'b1);
    end
  endtask

  task automatic t_layout();
    clear_hits();
    hit_main = 1'b1;
    main_cfg = mk(1'b1, 2'd2, 3'd5) | 8'h88;
    run();
    chk("R3 bits 7 and 3 ignored", fillc(mk(1'b1, 2'd2, 3'd5), 1'b0), 1'b1);
  endtask

  task automatic t_off();
    clear_hits();
    hit_main = 1'b1;
    main_cfg = mk(1'b0, 2'd3, 3'd7);
    run();
    chk("R6 main off black", 24'h0, 1'b1);
    clear_hits();
    hit_sub = 1'b1;
    sub_cfg = mk(1'b0, 2'd3, 3'd2);
    run();
    chk("R6 sub off black", 24'h0, 1'b1);
    clear_hits();
    hit_bg = 1'b1;
    bg_cfg = mk(1'b0, 2'd3, 3'd4);
    run();
    chk("R6 background off black", 24'h0, 1'b1);
  endtask

  task automatic t_priority();
    chan_cfg = mk(1'b1, 2'd3, 3'd2);
    sub_cfg  = mk(1'b1, 2'd3, 3'd4);
    main_cfg = mk(1'b1, 2'd3, 3'd1);
    bg_cfg   = mk(1'b1, 2'd3, 3'd7);
    {hit_chan, hit_sub, hit_main, hit_pic, hit_bg, fact_win} = 6'b111110;
    run();
    chk("R8 channel wins", fillc(chan_cfg, 1'b0), 1'b1);
    hit_chan = 1'b0;
    run();
    chk("R8 sub over main", fillc(sub_cfg, 1'b0), 1'b1);
    hit_sub = 1'b0;
    run();
    chk("R8 main over picture", fillc(main_cfg, 1'b0), 1'b1);
    hit_main = 1'b0;
    run();
    chk("R9 picture passthrough", {pic_y, pic_u, pic_v}, 1'b1);
    hit_pic = 1'b0;
    run();
    chk("R8 background last", fillc(bg_cfg, 1'b0), 1'b1);
    hit_bg = 1'b0;
    run();
    chk("R12 no region zeros", 24'h0, 1'b0);
  endtask

  task automatic t_chan_off();
    clear_hits();
    hit_chan = 1'b1;
    chan_cfg = mk(1'b0, 2'd3, 3'd2);
    sub_cfg  = mk(1'b1, 2'd1, 3'd6);
    run();
    chk("R7 channel off uses sub", fillc(sub_cfg, 1'b0), 1'b1);
    sub_cfg = mk(1'b0, 2'd1, 3'd6);
    run();
    chk("R7 channel and sub off black", 24'h0, 1'b1);
  endtask

  task automatic t_invert();
    uv_inv = 1'b1;
    clear_hits();
    hit_main = 1'b1;
    main_cfg = mk(1'b1, 2'd3, 3'd5);
    run();
    chk("R10 main border inverted", fillc(main_cfg, 1'b1), 1'b1);
    clear_hits();
    hit_chan = 1'b1;
    chan_cfg = mk(1'b1, 2'd2, 3'd3);
    run();
    chk("R10 channel border inverted", fillc(chan_cfg, 1'b1), 1'b1);
    clear_hits();
    hit_bg = 1'b1;
    bg_cfg = mk(1'b1, 2'd3, 3'd6);
    run();
    chk("R10 background not inverted", fillc(bg_cfg, 1'b0), 1'b1);
    clear_hits();
    hit_pic = 1'b1;
    run();
    chk("R10 picture not inverted", {pic_y, pic_u, pic_v}, 1'b1);
    uv_inv = 1'b0;
  endtask

  task automatic t_factory();
    bg_cfg   = 8'h80 | mk(1'b1, 2'd3, 3'd1);
    main_cfg = mk(1'b1, 2'd3, 3'd2);
    chan_cfg = mk(1'b1, 2'd3, 3'd4);
    clear_hits();
    {hit_chan, hit_main, fact_win} = 3'b111;
    run();
    chk("R11 factory floods window", fillc(mk(1'b1, 2'd3, 3'd1), 1'b0), 1'b1);
    clear_hits();
    hit_pic = 1'b1;
    run();
    chk("R11 factory outside window", 24'h0, 1'b0);
    bg_cfg = 8'h80 | mk(1'b0, 2'd3, 3'd1);
    clear_hits();
    {hit_main, fact_win} = 2'b11;
    run();
    chk("R11 factory needs enable", fillc(main_cfg, 1'b0), 1'b1);
    bg_cfg = 8'h00;
  endtask

  task automatic t_pipoff();
    pip_on = 1'b0;
    clear_hits();
    hit_bg = 1'b1;
    bg_cfg = mk(1'b1, 2'd2, 3'd5);
    run();
    chk("R12 pip off no blanking", fillc(bg_cfg, 1'b0), 1'b0);
    pip_on = 1'b1;
    run();
    chk("R12 pip on blanking", fillc(bg_cfg, 1'b0), 1'b1);
  endtask

  task automatic t_stall();
    clear_hits();
    hit_bg = 1'b1;
    bg_cfg = mk(1'b1, 2'd3, 3'd4);
    run();
    chk("R2 before stall", fillc(mk(1'b1, 2'd3, 3'd4), 1'b0), 1'b1);
    pix_en = 1'b0;
    bg_cfg = mk(1'b1, 2'd3, 3'd1);
    repeat (3) @(negedge clk);
    chk("R2 stalled hold", fillc(mk(1'b1, 2'd3, 3'd4), 1'b0), 1'b1);
    pix_en = 1'b1;
    @(posedge clk);
    @(negedge clk);
    chk("R2 one enabled edge", fillc(mk(1'b1, 2'd3, 3'd4), 1'b0), 1'b1);
    @(posedge clk);
    @(negedge clk);
    chk("R2 second enabled edge", fillc(bg_cfg, 1'b0), 1'b1);
  endtask

  initial begin
    rst_n = 1'b0; pix_en = 1'b1; pip_on = 1'b1; uv_inv = 1'b0;
    main_cfg = '0; sub_cfg = '0; chan_cfg = '0; bg_cfg = '0;
    {hit_chan, hit_sub, hit_main, hit_pic, hit_bg, fact_win} = '0;
    pic_y = 8'h5A; pic_u = 8'hE3; pic_v = 8'h21;
    @(negedge clk);
    t_reset();
    t_colours();
    t_levels();
    t_layout();
    t_off();
    t_priority();
    t_chan_off();
    t_invert();
    t_factory();
    t_pipoff();
    t_stall();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R2 watchdog: got hung run expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule